// File: doc/BRIEF.md
# Colour Text-Mode Raster Generator

This block drives a colour text display of 40 columns by 25 rows, each cell an 8 by 8 dot glyph. It keeps its own horizontal and vertical position counters. From them it forms the index of the cell under the beam, which addresses two parallel byte memories outside the block: one holds the character code of each cell and the other holds its colour attribute. Both memories are read at the same index. The character code, one bank bit from the attribute and the current glyph line together address an external glyph ROM. The returned dot byte is loaded into a shifter and sent out one dot per clock, most significant bit first.

Each dot takes the foreground colour of its cell when set and the background colour when clear. Each colour is three digital bits. The outputs are forced dark outside the visible window. Active-low horizontal and vertical sync pulses and a blanking flag come out on the same clock as the dots they belong to. The memories and the ROM must answer combinationally, within the clock in which they are addressed. Every output lags the internal position by exactly one clock.

Default timing suits a roughly 8.867 MHz dot clock: 568 clocks per line (about 64 µs), 320 of them visible (about 36 µs), and 312 lines per field (about 50 Hz). Every dimension is a parameter.

Top module: `txtvid_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every counter clears synchronously. During reset and in the clock that follows, `blank`=1, `hsync_n`=1, `vsync_n`=1 and red/green/blue=0. After release, the raster starts at dot 0 of line 0.
- R2: `vram_addr` equals cell_row*COLS + cell_col, where cell_col = h/8 and cell_row = v/8 for the current position (h, v). Within each visible cell it is held for the cell's 8 clocks.
- R3: `glyph_addr` is {attribute bit 7, character code, glyph line}. Bit 11 is the bank select, bits 10..3 are the code and bits 2..0 are the line.
- R4: The glyph line index (`glyph_addr[2:0]`) equals v mod 8. It advances once per line, wraps from 7 to 0, returns to 0 at the start of each frame and does not change inside a line.
- R5: The dot for visible position h is bit (7 - h mod 8) of the glyph byte, so the most significant bit is the leftmost dot. The output appears one clock after the position counter holds h.
- R6: A set dot shows the foreground colour: green = attribute bit 6, red = bit 5, blue = bit 4. A clear dot shows the background colour: green = bit 2, red = bit 1, blue = bit 0. Attribute bit 3 has no effect.
- R7: `blank` is 1 exactly when h >= COLS*8 or v >= ROWS*8. While `blank` is 1, red, green and blue are all 0.
- R8: `hsync_n` is 0 for H_SYNC_LEN clocks starting at h = H_SYNC_START on every line, and that pulse lies inside horizontal blanking.
- R9: `vsync_n` is 0 on V_SYNC_LEN whole lines starting at line V_SYNC_START, which lie inside vertical blanking.
- R10: A line lasts H_TOTAL clocks and a frame V_TOTAL lines. The pattern repeats identically from frame to frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| vram_addr | output | $clog2(COLS*ROWS) | Cell index for the code and attribute memories |
| code_in | input | 8 | Character code read at `vram_addr` |
| attr_in | input | 8 | Colour attribute read at `vram_addr` |
| glyph_addr | output | 12 | Glyph ROM address {bank, code, line} |
| glyph_in | input | 8 | Glyph ROM dot byte |
| red | output | 1 | Red dot output |
| green | output | 1 | Green dot output |
| blue | output | 1 | Blue dot output |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible window |

## Verification
Each cell gets a different character code and a different attribute, derived from the cell index. The glyph ROM scrambles its address, so adjacent cells, both glyph banks, and attributes with bit 3 set and clear all appear in the expected stream. A swapped colour bit, a reversed dot order or a one-clock misalignment therefore shows up as a wrong dot somewhere. The address and ROM-address streams are compared on every visible clock, which separates a stale cell index from a wrong line index. A run across more than two frames, followed by a mid-frame reset and restart, shows that frame wrap and reset both return the raster to the top-left cell.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;
    localparam int GLYPH_W  = 8;   // dots per cell row
    localparam int CW_BITS  = 3;   // log2 of cell width
    localparam int ROW_W    = 3;   // glyph line index width
    localparam int CODE_W   = 8;
    localparam int ATTR_W   = 8;
    localparam int GADDR_W  = 1 + CODE_W + ROW_W;

    // attribute field positions (decoded by the colour path)
    localparam int ATTR_BANK  = 7;
    localparam int ATTR_FG_LO = 4;
    localparam int ATTR_BG_LO = 0;

    typedef logic [2:0] rgb3_t;    // {green, red, blue}

    typedef struct packed {
        logic [GLYPH_W-1:0] dots;
        rgb3_t              fg;
        rgb3_t              bg;
    } shift_state_t;
endpackage

// File: rtl/txtvid_timing.sv
module txtvid_timing
    import txtvid_pkg::*;
#(
    parameter int COLS         = 40,
    parameter int ROWS         = 25,
    parameter int H_TOTAL      = 568,
    parameter int H_SYNC_START = 400,
    parameter int H_SYNC_LEN   = 40,
    parameter int V_TOTAL      = 312,
    parameter int V_SYNC_START = 240,
    parameter int V_SYNC_LEN   = 3,
    localparam int AW = $clog2(COLS*ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [AW-1:0]    cell_addr,
    output logic [ROW_W-1:0] glyph_row,
    output logic             fetch,
    output logic             blank_o,
    output logic             hsync_n_o,
    output logic             vsync_n_o
);
    localparam int HW       = $clog2(H_TOTAL);
    localparam int VW       = $clog2(V_TOTAL);
    localparam int H_ACTIVE = COLS << CW_BITS;
    localparam int V_ACTIVE = ROWS << CW_BITS;

    localparam logic [HW-1:0]    H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0]    H_ACT   = HW'(H_ACTIVE);
    localparam logic [HW-1:0]    H_SS    = HW'(H_SYNC_START);
    localparam logic [HW-1:0]    H_SE    = HW'(H_SYNC_START + H_SYNC_LEN);
    localparam logic [VW-1:0]    V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0]    V_ACT   = VW'(V_ACTIVE);
    localparam logic [VW-1:0]    V_SS    = VW'(V_SYNC_START);
    localparam logic [VW-1:0]    V_SE    = VW'(V_SYNC_START + V_SYNC_LEN);
    localparam logic [AW-1:0]    COLS_C  = AW'(COLS);
    localparam logic [ROW_W-1:0] ROW_END = '1;

    typedef struct packed {
        logic [HW-1:0]    h;
        logic [VW-1:0]    v;
        logic [ROW_W-1:0] row;
        logic [AW-1:0]    base;
        logic             blank;
        logic             hs_n;
        logic             vs_n;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    visible;
    logic    line_end;
    logic    frame_end;

    always_comb begin
        visible   = (st_q.h < H_ACT) && (st_q.v < V_ACT);
        line_end  = (st_q.h == H_LAST);
        frame_end = line_end && (st_q.v == V_LAST);

        st_d       = st_q;
        st_d.h     = line_end ? '0 : st_q.h + 1'b1;
        if (line_end) begin
            if (frame_end) begin
                st_d.v    = '0;
                st_d.row  = '0;
                st_d.base = '0;
            end else begin
                st_d.v   = st_q.v + 1'b1;
                st_d.row = st_q.row + 1'b1;
                if (st_q.row == ROW_END) begin
                    st_d.base = st_q.base + COLS_C;
                end
            end
        end
        // delayed by one clock to line up with the dot shifter
        st_d.blank = !visible;
        st_d.hs_n  = !((st_q.h >= H_SS) && (st_q.h < H_SE));
        st_d.vs_n  = !((st_q.v >= V_SS) && (st_q.v < V_SE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.blank <= 1'b1;
            st_q.hs_n  <= 1'b1;
            st_q.vs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cell_addr = st_q.base + AW'(st_q.h >> CW_BITS);
    assign glyph_row = st_q.row;
    assign fetch     = visible && (st_q.h[CW_BITS-1:0] == '0);
    assign blank_o   = st_q.blank;
    assign hsync_n_o = st_q.hs_n;
    assign vsync_n_o = st_q.vs_n;
endmodule

// File: rtl/txtvid_shifter.sv
module txtvid_shifter
    import txtvid_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_n,
    input  logic [GLYPH_W-1:0] dots_in,
    input  rgb3_t              fg_in,
    input  rgb3_t              bg_in,
    output logic               dot,
    output rgb3_t              fg,
    output rgb3_t              bg
);
    shift_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!load_n) begin
            sh_d.dots = dots_in;
            sh_d.fg   = fg_in;
            sh_d.bg   = bg_in;
        end else begin
            sh_d.dots = {sh_q.dots[GLYPH_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dot = sh_q.dots[GLYPH_W-1];
    assign fg  = sh_q.fg;
    assign bg  = sh_q.bg;
endmodule

// File: rtl/txtvid_colour.sv
module txtvid_colour
    import txtvid_pkg::*;
(
    input  logic  dot,
    input  rgb3_t fg,
    input  rgb3_t bg,
    input  logic  blank,
    output logic  red,
    output logic  green,
    output logic  blue
);
    rgb3_t sel;

    always_comb begin
        if (blank)    sel = '0;
        else if (dot) sel = fg;
        else          sel = bg;
        green = sel[2];
        red   = sel[1];
        blue  = sel[0];
    end
endmodule

// File: rtl/txtvid_gen.sv
module txtvid_gen
    import txtvid_pkg::*;
#(
    parameter int COLS         = 40,
    parameter int ROWS         = 25,
    parameter int H_TOTAL      = 568,
    parameter int H_SYNC_START = 400,
    parameter int H_SYNC_LEN   = 40,
    parameter int V_TOTAL      = 312,
    parameter int V_SYNC_START = 240,
    parameter int V_SYNC_LEN   = 3,
    localparam int AW = $clog2(COLS*ROWS)
) (
    input  logic               clk,
    input  logic               rst,
    output logic [AW-1:0]      vram_addr,
    input  logic [CODE_W-1:0]  code_in,
    input  logic [ATTR_W-1:0]  attr_in,
    output logic [GADDR_W-1:0] glyph_addr,
    input  logic [GLYPH_W-1:0] glyph_in,
    output logic               red,
    output logic               green,
    output logic               blue,
    output logic               hsync_n,
    output logic               vsync_n,
    output logic               blank
);
    logic [ROW_W-1:0] row;
    logic             fetch;
    logic             dot;
    rgb3_t            fg, bg;
    logic             unused_attr_bit;

    assign unused_attr_bit = attr_in[3];

    txtvid_timing #(
        .COLS(COLS), .ROWS(ROWS),
        .H_TOTAL(H_TOTAL), .H_SYNC_START(H_SYNC_START), .H_SYNC_LEN(H_SYNC_LEN),
        .V_TOTAL(V_TOTAL), .V_SYNC_START(V_SYNC_START), .V_SYNC_LEN(V_SYNC_LEN)
    ) u_timing (
        .clk       (clk),
        .rst       (rst),
        .cell_addr (vram_addr),
        .glyph_row (row),
        .fetch     (fetch),
        .blank_o   (blank),
        .hsync_n_o (hsync_n),
        .vsync_n_o (vsync_n)
    );

    assign glyph_addr = {attr_in[ATTR_BANK], code_in, row};

    txtvid_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_n  (!fetch),
        .dots_in (glyph_in),
        .fg_in   (attr_in[ATTR_FG_LO +: 3]),
        .bg_in   (attr_in[ATTR_BG_LO +: 3]),
        .dot     (dot),
        .fg      (fg),
        .bg      (bg)
    );

    txtvid_colour u_colour (
        .dot   (dot),
        .fg    (fg),
        .bg    (bg),
        .blank (blank),
        .red   (red),
        .green (green),
        .blue  (blue)
    );
endmodule

// File: rtl/txtvid_chk.sv
module txtvid_chk #(
    parameter int COLS    = 40,
    parameter int ROWS    = 25,
    parameter int H_TOTAL = 568,
    localparam int AW = $clog2(COLS*ROWS)
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] vram_addr,
    input logic [2:0]    row_idx,
    input logic          red,
    input logic          green,
    input logic          blue,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          blank
);
    localparam int HW = $clog2(H_TOTAL);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT  = HW'(COLS * 8);

    logic [HW-1:0] hc_q;

    always_ff @(posedge clk) begin
        if (rst)                 hc_q <= '0;
        else if (hc_q == H_LAST) hc_q <= '0;
        else                     hc_q <= hc_q + 1'b1;
    end

    assert_hsync_in_blank_R8: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> blank);

    assert_vsync_in_blank_R9: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> blank);

    assert_dark_when_blank_R7: assert property (@(posedge clk) disable iff (rst)
        blank |-> ({red, green, blue} == 3'b000));

    assert_cell_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ((hc_q < H_ACT) && (hc_q[2:0] != 3'd0)) |-> $stable(vram_addr));

    assert_row_steady_in_line_R4: assert property (@(posedge clk) disable iff (rst)
        (hc_q != '0) |-> $stable(row_idx));
endmodule

bind txtvid_gen txtvid_chk #(
    .COLS(COLS), .ROWS(ROWS), .H_TOTAL(H_TOTAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vram_addr (vram_addr),
    .row_idx   (glyph_addr[2:0]),
    .red       (red),
    .green     (green),
    .blue      (blue),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .blank     (blank)
);

// File: tb/txtvid_gen_tb.sv
module txtvid_gen_tb;
    localparam int COLS = 4, ROWS = 3;
    localparam int HT = 48, HSS = 36, HSL = 4;
    localparam int VT = 30, VSS = 26, VSL = 2;
    localparam int HA = COLS * 8, VA = ROWS * 8;
    localparam int FRAME = HT * VT;
    localparam int AW = $clog2(COLS*ROWS);

    typedef struct {
        int          pos;
        logic        r, g, b, hs_n, vs_n, blk;
        logic        aval;
        logic [AW-1:0] addr;
        logic [11:0] gaddr;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] vram_addr;
    logic [7:0]    code_in, attr_in, glyph_in;
    logic [11:0]   glyph_addr;
    logic red, green, blue, hsync_n, vsync_n, blank;

    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    bit   done   = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    function automatic logic [7:0] code_fn(input int c);
        return 8'(c * 29 + 5);
    endfunction
    function automatic logic [7:0] attr_fn(input int c);
        return 8'(c * 53 + 154);
    endfunction
    function automatic logic [7:0] glyph_fn(input logic [11:0] a);
        logic [11:0] t;
        t = a * 12'd157;
        return t[7:0] ^ t[11:4];
    endfunction

    // memories and glyph ROM seen by the design
    assign code_in  = code_fn(int'(vram_addr));
    assign attr_in  = attr_fn(int'(vram_addr));
    assign glyph_in = glyph_fn(glyph_addr);

    txtvid_gen #(
        .COLS(COLS), .ROWS(ROWS),
        .H_TOTAL(HT), .H_SYNC_START(HSS), .H_SYNC_LEN(HSL),
        .V_TOTAL(VT), .V_SYNC_START(VSS), .V_SYNC_LEN(VSL)
    ) u_dut (
        .clk(clk), .rst(rst), .vram_addr(vram_addr), .code_in(code_in),
        .attr_in(attr_in), .glyph_addr(glyph_addr), .glyph_in(glyph_in),
        .red(red), .green(green), .blue(blue),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp, input int pos);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos=%0d actual=%h expected=%h", tag, pos, act, exp);
        end
    endtask

    // driver: expected stream for n clocks after reset release
    task automatic push_expected(input int n);
        for (int p = 0; p < n; p++) begin
            exp_t e;
            int fp, h, v, c, qp, qh, qv, qc;
            logic [7:0] a, cd, gl;
            logic act, d;
            fp = p % FRAME; h = fp % HT; v = fp / HT;
            act = (h < HA) && (v < VA);
            c  = (v / 8) * COLS + h / 8;
            a  = attr_fn(c); cd = code_fn(c);
            gl = glyph_fn({a[7], cd, 3'(v % 8)});
            d  = gl[7 - (h % 8)];
            e.pos  = p;
            e.g    = act & (d ? a[6] : a[2]);
            e.r    = act & (d ? a[5] : a[1]);
            e.b    = act & (d ? a[4] : a[0]);
            e.blk  = !act;
            e.hs_n = !((h >= HSS) && (h < HSS + HSL));
            e.vs_n = !((v >= VSS) && (v < VSS + VSL));
            qp = (p + 1) % FRAME; qh = qp % HT; qv = qp / HT;
            qc = (qv / 8) * COLS + qh / 8;
            e.aval  = (qh < HA) && (qv < VA);
            e.addr  = AW'(qc);
            e.gaddr = {attr_fn(qc)[7], code_fn(qc), 3'(qv % 8)};
            q.push_back(e);
        end
    endtask

    // monitor: one expected item per clock, sampled mid-cycle
    always @(negedge clk) begin
        if (mon_en && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R5 R6 dot colour", {13'd0, red, green, blue}, {13'd0, e.r, e.g, e.b}, e.pos);
            chk("R7 blank",         {15'd0, blank},   {15'd0, e.blk},  e.pos);
            chk("R8 R10 hsync",     {15'd0, hsync_n}, {15'd0, e.hs_n}, e.pos);
            chk("R9 R10 vsync",     {15'd0, vsync_n}, {15'd0, e.vs_n}, e.pos);
            if (e.aval) begin
                chk("R2 cell address",  16'(vram_addr),        16'(e.addr),        e.pos + 1);
                chk("R3 glyph address", {4'd0, glyph_addr},    {4'd0, e.gaddr},    e.pos + 1);
                chk("R4 glyph line",    {13'd0, glyph_addr[2:0]}, {13'd0, e.gaddr[2:0]}, e.pos + 1);
            end
        end
    end

    task automatic check_reset_state();
        chk("R1 reset blank", {15'd0, blank},   16'd1, -1);
        chk("R1 reset hsync", {15'd0, hsync_n}, 16'd1, -1);
        chk("R1 reset vsync", {15'd0, vsync_n}, 16'd1, -1);
        chk("R1 reset dark",  {13'd0, red, green, blue}, 16'd0, -1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        #2;
        rst = 1'b0;
        push_expected(2 * FRAME + 150);   // R10 across two frame wraps
        mon_en = 1'b1;
        wait (q.size() == 0);
        @(negedge clk); #2;
        mon_en = 1'b0;
        rst = 1'b1;                        // R1 mid-frame reset
        repeat (2) @(negedge clk);
        check_reset_state();
        #2;
        rst = 1'b0;
        push_expected(HT * 10 + 7);
        mon_en = 1'b1;
        wait (q.size() == 0);
        @(negedge clk);
        finish_run();
    end
endmodule